// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps a seconds-to-years calendar in packed BCD and shows it to software as eight byte-wide registers. The registers occupy the top eight byte addresses of a 32K-byte space, behind a single-cycle synchronous read/write port. A one-cycle pulse on `tick_1hz` advances the internal counters. On the same edge the user-visible registers are refreshed from the counters, unless software has frozen them.

The user registers are a separate copy of the counters. Software sets the freeze bit to read a coherent time while the counters keep running. It sets the load bit, writes new time values into the registers, and then clears the load bit; the registers are copied into the counters in one cycle. A stop bit holds the counters. A century-enable bit lets the century flag toggle when the year wraps. Both century bits can be written directly, without the load bit.

Top module: `bcdcal_regs`

## Requirements
- R1: Only addresses whose upper bits are all ones hold clock registers. The low three address bits select the slot: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month, 7 year. Any other address reads 8'h00 and ignores writes. Read data appears on `rdata` in the cycle after the request and holds until the next read.
- R2: When running, each tick advances the time in BCD. Seconds and minutes wrap 59 to 00 and carry. Hours wrap 23 to 00 and carry. Day-of-week counts 1 to 7 and then wraps to 1.
- R3: The date wraps to 01 after the last day of the month, and the month increments. The last day is 28 for month 02 (29 if the BCD year is divisible by 4), 30 for months 04, 06, 09 and 11, and 31 otherwise. Month 12 wraps to 01 and the year increments.
- R4: Year 99 wraps to 00. The century flag (day register bit 4) inverts at that wrap only when century-enable (day register bit 5) is 1.
- R5: While the freeze bit (control bit 6) is 1, ticks do not change the user time registers, although the counters keep counting. After the bit is cleared, the next tick refreshes the registers with the current count.
- R6: The load bit (control bit 7) also blocks refresh. A control write that clears it while it is set copies all user time registers into the counters. The next tick advances from the loaded values.
- R7: Seconds register bit 7 is the stop bit. While it is 1 the counters do not advance. It resets to 1.
- R8: After reset, control reads 8'h00, seconds reads 8'h80, minutes and hours read 8'h00, day-of-week reads 8'h01 (frequency-test, century-enable and century flag all 0), date reads 8'h01, month reads 8'h01 and year reads 8'h00.
- R9: Bits with no function read back 0: minutes bit 7, hours bits 7:6, day bits 7 and 3, date bits 7:6, month bits 7:5. The frequency-test flag is day bit 6.
- R10: A write to the day register updates the century-enable and century-flag bits at once, in both the registers and the counters, whatever the state of the load bit.
- R11: When a tick lands in the same cycle as the commit write, the commit wins. The counters hold the loaded values for that cycle and the user registers are not refreshed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| cs | input | 1 | Port select |
| we | input | 1 | Write when 1, read when 0 (with cs) |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
Checks that hold on every cycle:
- `rdata` holds between reads.
- A set stop bit freezes the counters.
- A set freeze or load bit keeps the user time registers still while the port is idle.
- A commit lands the user registers in the counters one cycle later.
- The seconds carry and the century-flag toggle or hold follow the enable bit.

Only the bench scenarios can show the calendar results through the read port: month lengths with and without a leap year, zeroed bits, the reset image, and the ordering of a commit against a coincident tick.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    typedef struct packed {
        logic       cb;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [5:0] trim;
        logic       stop;
        logic       ft;
        logic       ceb;
    } cal_ctrl_t;

    typedef enum logic [2:0] {
        SLOT_CTRL = 3'd0,
        SLOT_SEC  = 3'd1,
        SLOT_MIN  = 3'd2,
        SLOT_HR   = 3'd3,
        SLOT_DOW  = 3'd4,
        SLOT_DATE = 3'd5,
        SLOT_MON  = 3'd6,
        SLOT_YR   = 3'd7
    } slot_e;

    localparam cal_time_t TIME_RST = '{cb: 1'b0, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                       dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};
    localparam cal_ctrl_t CTRL_RST = '{wr: 1'b0, rd: 1'b0, trim: 6'h00,
                                       stop: 1'b1, ft: 1'b0, ceb: 1'b0};

    // BCD increment of a two-digit value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Year is a multiple of four when (2*tens + ones) mod 4 is zero.
    function automatic logic leap_year(input logic [7:0] yr);
        logic [1:0] r;
        r = yr[1:0] + {yr[4], 1'b0};
        return (r == 2'd0);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcdcal_counter.sv
module bcdcal_counter
    import bcdcal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      run,
    input  logic      load,
    input  cal_time_t load_val,
    input  logic      cb_wr,
    input  logic      cb_val,
    input  logic      ceb,
    output cal_time_t cnt_o,
    output cal_time_t nxt_o
);

    cal_time_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (tick && run) begin
            if (cnt_q.sec == 8'h59) begin
                cnt_d.sec = 8'h00;
                if (cnt_q.min == 8'h59) begin
                    cnt_d.min = 8'h00;
                    if (cnt_q.hr == 8'h23) begin
                        cnt_d.hr  = 8'h00;
                        cnt_d.dow = (cnt_q.dow == 8'h07) ? 8'h01 : bcd_inc(cnt_q.dow);
                        if (cnt_q.date == month_last(cnt_q.mon, cnt_q.yr)) begin
                            cnt_d.date = 8'h01;
                            if (cnt_q.mon == 8'h12) begin
                                cnt_d.mon = 8'h01;
                                if (cnt_q.yr == 8'h99) begin
                                    cnt_d.yr = 8'h00;
                                    if (ceb) cnt_d.cb = ~cnt_q.cb;
                                end else begin
                                    cnt_d.yr = bcd_inc(cnt_q.yr);
                                end
                            end else begin
                                cnt_d.mon = bcd_inc(cnt_q.mon);
                            end
                        end else begin
                            cnt_d.date = bcd_inc(cnt_q.date);
                        end
                    end else begin
                        cnt_d.hr = bcd_inc(cnt_q.hr);
                    end
                end else begin
                    cnt_d.min = bcd_inc(cnt_q.min);
                end
            end else begin
                cnt_d.sec = bcd_inc(cnt_q.sec);
            end
        end
        if (cb_wr) cnt_d.cb = cb_val;
        if (load)  cnt_d    = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TIME_RST;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign nxt_o = cnt_d;

endmodule

// File: rtl/bcdcal_mirror.sv
module bcdcal_mirror
    import bcdcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  slot_e      slot,
    input  logic [7:0] wdata,
    input  cal_time_t  cnt_nxt,
    output cal_time_t  mir_o,
    output cal_ctrl_t  ctrl_o,
    output logic       commit_o,
    output logic       cb_wr_o,
    output logic       cb_val_o
);

    typedef struct packed {
        cal_time_t t;
        cal_ctrl_t c;
    } mir_state_t;

    mir_state_t st_q, st_d;
    logic       commit_d;
    logic       refresh_d;

    always_comb begin
        st_d      = st_q;
        commit_d  = wr_en && (slot == SLOT_CTRL) && st_q.c.wr && !wdata[7];
        refresh_d = tick && !st_q.c.rd && !st_q.c.wr;

        if (refresh_d) st_d.t = cnt_nxt;

        if (wr_en) begin
            case (slot)
                SLOT_CTRL: begin
                    st_d.c.wr   = wdata[7];
                    st_d.c.rd   = wdata[6];
                    st_d.c.trim = wdata[5:0];
                end
                SLOT_SEC: begin
                    st_d.c.stop = wdata[7];
                    st_d.t.sec  = {1'b0, wdata[6:0]};
                end
                SLOT_MIN:  st_d.t.min  = {1'b0, wdata[6:0]};
                SLOT_HR:   st_d.t.hr   = {2'b00, wdata[5:0]};
                SLOT_DOW: begin
                    st_d.c.ft  = wdata[6];
                    st_d.c.ceb = wdata[5];
                    st_d.t.cb  = wdata[4];
                    st_d.t.dow = {5'b0, wdata[2:0]};
                end
                SLOT_DATE: st_d.t.date = {2'b00, wdata[5:0]};
                SLOT_MON:  st_d.t.mon  = {3'b000, wdata[4:0]};
                default:   st_d.t.yr   = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.t <= TIME_RST;
            st_q.c <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mir_o    = st_q.t;
    assign ctrl_o   = st_q.c;
    assign commit_o = commit_d;
    assign cb_wr_o  = wr_en && (slot == SLOT_DOW);
    assign cb_val_o = wdata[4];

endmodule

// File: rtl/bcdcal_regs.sv
module bcdcal_regs
    import bcdcal_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int SLOT_W    = 3;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    logic                 in_range;
    logic [NUM_SLOTS-1:0] slot_hit;
    slot_e                slot;
    cal_time_t            cnt_w, nxt_w, mir_w;
    cal_ctrl_t            ctrl_w;
    logic                 commit_w, cb_wr_w, cb_val_w;
    logic                 stop_w, rd_halt_w, wr_halt_w, ceb_w;
    logic [7:0]           rdata_q, rdata_d;
    logic [7:0]           slot_byte [NUM_SLOTS];

    assign in_range = &addr[ADDR_W-1:SLOT_W];
    assign slot     = slot_e'(addr[SLOT_W-1:0]);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
        assign slot_hit[g] = in_range && (addr[SLOT_W-1:0] == SLOT_W'(g));
    end

    bcdcal_mirror u_mirror (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .wr_en    (cs && we && in_range),
        .slot     (slot),
        .wdata    (wdata),
        .cnt_nxt  (nxt_w),
        .mir_o    (mir_w),
        .ctrl_o   (ctrl_w),
        .commit_o (commit_w),
        .cb_wr_o  (cb_wr_w),
        .cb_val_o (cb_val_w)
    );

    bcdcal_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .run      (!ctrl_w.stop),
        .load     (commit_w),
        .load_val (mir_w),
        .cb_wr    (cb_wr_w),
        .cb_val   (cb_val_w),
        .ceb      (ctrl_w.ceb),
        .cnt_o    (cnt_w),
        .nxt_o    (nxt_w)
    );

    assign stop_w    = ctrl_w.stop;
    assign rd_halt_w = ctrl_w.rd;
    assign wr_halt_w = ctrl_w.wr;
    assign ceb_w     = ctrl_w.ceb;

    always_comb begin
        slot_byte[SLOT_CTRL] = {ctrl_w.wr, ctrl_w.rd, ctrl_w.trim};
        slot_byte[SLOT_SEC]  = {ctrl_w.stop, mir_w.sec[6:0]};
        slot_byte[SLOT_MIN]  = {1'b0, mir_w.min[6:0]};
        slot_byte[SLOT_HR]   = {2'b00, mir_w.hr[5:0]};
        slot_byte[SLOT_DOW]  = {1'b0, ctrl_w.ft, ctrl_w.ceb, mir_w.cb, 1'b0, mir_w.dow[2:0]};
        slot_byte[SLOT_DATE] = {2'b00, mir_w.date[5:0]};
        slot_byte[SLOT_MON]  = {3'b000, mir_w.mon[4:0]};
        slot_byte[SLOT_YR]   = mir_w.yr;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (cs && !we) begin
            rdata_d = 8'h00;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (slot_hit[i]) rdata_d = slot_byte[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/bcdcal_regs_chk.sv
module bcdcal_regs_chk
    import bcdcal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      cs,
    input logic      we,
    input logic [7:0] rdata,
    input logic      stop,
    input logic      rd_halt,
    input logic      wr_halt,
    input logic      ceb,
    input logic      commit,
    input logic      cb_wr,
    input cal_time_t cnt,
    input cal_time_t mir
);

    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> $stable(rdata));

    p_sec_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop && !commit && !cb_wr && cnt.sec == 8'h59)
        |=> (cnt.sec == 8'h00 && cnt.min != $past(cnt.min)));

    p_cb_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop && !commit && !cb_wr && ceb &&
         {cnt.yr, cnt.mon, cnt.date, cnt.hr, cnt.min, cnt.sec} == 48'h99_12_31_23_59_59)
        |=> (cnt.cb != $past(cnt.cb) && cnt.yr == 8'h00));

    p_cb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ceb && !commit && !cb_wr) |=> $stable(cnt.cb));

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_halt || wr_halt) && !(cs && we)) |=> $stable(mir));

    p_commit_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt == $past(mir)));

    p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !commit && !cb_wr) |=> $stable(cnt));

endmodule

bind bcdcal_regs bcdcal_regs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1hz),
    .cs      (cs),
    .we      (we),
    .rdata   (rdata),
    .stop    (stop_w),
    .rd_halt (rd_halt_w),
    .wr_halt (wr_halt_w),
    .ceb     (ceb_w),
    .commit  (commit_w),
    .cb_wr   (cb_wr_w),
    .cnt     (cnt_w),
    .mir     (mir_w)
);

// File: tb/bcdcal_regs_tb_top.sv
`timescale 1ns/1ps
module bcdcal_regs_tb_top;

    localparam logic [14:0] A_CTL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                            A_HR  = 15'h7FFB, A_DOW = 15'h7FFC, A_DAT = 15'h7FFD,
                            A_MON = 15'h7FFE, A_YR  = 15'h7FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    bcdcal_regs dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Monitor: a read is requested at one edge; rdata is compared at the next falling edge.
    always @(posedge clk) rd_seen <= cs && !we;

    always @(negedge clk) begin
        if (rd_seen) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard R1: unexpected read result %02h, expected none", rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, input logic [7:0] e, input string t);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); cs = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic load_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dt,
                             input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(A_CTL, 8'h80);
        wr(A_YR, y); wr(A_MON, mo); wr(A_DAT, dt);
        wr(A_HR, h); wr(A_MIN, mi); wr(A_SEC, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset image
        rd(A_CTL, 8'h00, "R8 ctrl");
        rd(A_SEC, 8'h80, "R8/R7 sec stop set");
        rd(A_MIN, 8'h00, "R8 min");
        rd(A_HR,  8'h00, "R8 hr");
        rd(A_DOW, 8'h01, "R8 dow");
        rd(A_DAT, 8'h01, "R8 date");
        rd(A_MON, 8'h01, "R8 mon");
        rd(A_YR,  8'h00, "R8 yr");

        // R1 addresses outside the clock slots
        wr(15'h7FF0, 8'h5A);
        rd(15'h7FF0, 8'h00, "R1 low address reads zero");
        wr(15'h3FF9, 8'h33);
        rd(A_SEC, 8'h80, "R1 aliased write ignored");

        // R7 stop holds the count
        tick1(); tick1();
        rd(A_SEC, 8'h80, "R7 stopped seconds");

        // R6/R9/R3 load non-leap Feb 28 23:59:58, day 7
        load_time(8'h23, 8'hE2, 8'h28, 8'h23, 8'h59, 8'h58);
        wr(A_DOW, 8'h8F);
        rd(A_DOW, 8'h07, "R9 day zero bits");
        rd(A_MON, 8'h02, "R9 month zero bits");
        rd(A_CTL, 8'h80, "R6 load bit readback");
        wr(A_CTL, 8'h00);
        rd(A_SEC, 8'h58, "R6 loaded seconds");
        tick1();
        rd(A_SEC, 8'h59, "R2 seconds step");
        tick1();
        rd(A_SEC, 8'h00, "R2 seconds wrap");
        rd(A_MIN, 8'h00, "R2 minutes wrap");
        rd(A_HR,  8'h00, "R2 hours wrap");
        rd(A_DOW, 8'h01, "R2 day-of-week wrap");
        rd(A_DAT, 8'h01, "R3 non-leap Feb end");
        rd(A_MON, 8'h03, "R3 month after Feb");

        // R3 leap year
        load_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        wr(A_CTL, 8'h00);
        tick1();
        rd(A_DAT, 8'h29, "R3 leap Feb 29");
        rd(A_MON, 8'h02, "R3 leap month held");
        rd(A_DOW, 8'h02, "R2 day-of-week step");

        // R3 thirty-day month
        load_time(8'h24, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        wr(A_CTL, 8'h00);
        tick1();
        rd(A_DAT, 8'h01, "R3 April end");
        rd(A_MON, 8'h05, "R3 month after April");

        // R5 freeze while counters run
        wr(A_CTL, 8'h40);
        tick1(); tick1();
        rd(A_SEC, 8'h00, "R5 frozen seconds");
        wr(A_CTL, 8'h00);
        rd(A_SEC, 8'h00, "R5 no refresh before tick");
        tick1();
        rd(A_SEC, 8'h03, "R5 refresh after release");

        // R11 commit coincident with tick
        wr(A_CTL, 8'h80);
        wr(A_SEC, 8'h10);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = A_CTL; wdata = 8'h00; tick_1hz = 1'b1;
        @(negedge clk); cs = 1'b0; we = 1'b0; tick_1hz = 1'b0;
        rd(A_SEC, 8'h10, "R11 no refresh at commit");
        tick1();
        rd(A_SEC, 8'h11, "R11 advance from loaded value");

        // R10 century bits written directly
        wr(A_DOW, 8'h27);
        rd(A_DOW, 8'h27, "R10 century bits immediate");

        // R4 century toggle enabled
        load_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        wr(A_CTL, 8'h00);
        tick1();
        rd(A_YR,  8'h00, "R4 year wrap");
        rd(A_MON, 8'h01, "R4 month wrap");
        rd(A_DOW, 8'h31, "R4 century flag toggled");

        // R4 century toggle disabled
        wr(A_CTL, 8'h80);
        wr(A_DOW, 8'h17);
        load_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        wr(A_CTL, 8'h00);
        tick1();
        rd(A_YR,  8'h00, "R4 year wrap no enable");
        rd(A_DOW, 8'h11, "R4 century flag held");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard R1: %0d reads pending, expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog R1: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule